// File: doc/BRIEF.md
# Bit-Error Pattern Checker

This block takes a stream of W bits per clock, qualified by a valid strobe, and compares it against a chosen reference sequence. The reference can be a short pseudo-random sequence, a long pseudo-random sequence, or a 64-bit repeating pattern supplied by the user. An independent invert control complements the reference before the comparison. The checker locks onto the incoming stream on its own and then counts bit errors.

Once it is locked, the checker counts mismatched bits in one of two ways. In infinite mode it counts without end. Otherwise it counts over a measurement window of fixed length and latches the result at the end of each window. The count is given both as a raw binary value and as an 8-bit floating-point value. When lock is lost, the count is forced to its maximum, so a loss of lock can be told apart from a high error rate.

Top module: `pattern_err_checker`

## Requirements
- R1: After reset, `syncLost` is 1 and `errCount` and `errFloat` are 0.
- R2: `patSel` selects the reference:
  - 0 selects the short sequence s[n] = s[n-6] xor s[n-7].
  - 1 selects the long sequence s[n] = s[n-28] xor s[n-31].
  - 2 or 3 selects the user pattern, whose bit 0 comes first in time.
  - `chkInvert` = 1 compares every received bit against the complement of the reference.
  - `dataIn` bit 0 is the earliest bit of the word.
- R3: The checker locks as follows, and `syncLost` falls once 64 consecutive bits, counted in whole words, have been error-free:
  - For the pseudo-random references, the prediction is seeded from the received bits while out of lock.
  - For the user pattern, every word that contains an error while out of lock moves the pattern phase one extra bit.
- R4: On the clock edge where lock is gained, the error count becomes 0.
- R5: While locked, each valid word adds to the count the number of bits that differ from the expected word.
- R6: While locked, lock is lost when more than 8 of the last 64 checked bits were in error. The count is then forced to all ones (`errFloat` reads 0xFF at the default width) and stays there until lock is gained again.
- R7: `timeBase` selects the measurement window:
  - 0 selects infinite mode, in which `errCount` follows the live count and saturates at all ones.
  - 1, 2 and 3 select windows of 2^WIN_EXP_S, 2^WIN_EXP_M and 2^WIN_EXP_L bits (by default 2^20, 2^26 and 2^32).
- R8: In a finite window, `errCount` changes only at the end of a window, where it takes that window's error total. The next window then starts again from zero.
- R9: Any change of `timeBase` clears the count to 0 and restarts the window.
- R10: `errFloat` encodes the count in two 4-bit fields:
  - The upper nibble holds the exponent e and the lower nibble holds the mantissa m.
  - m·2^e is the count truncated, using the smallest e that keeps m ≤ 15.
  - Counts above 15·2^15 give 0xFF.
- R11: An all-zeros stream with `patSel` = 0 and `chkInvert` = 0 gains lock and reports no errors.
- R12: Cycles with `dataValid` low change neither the lock state nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | DATA_W | Received word, bit 0 first in time |
| dataValid | input | 1 | Word qualifier |
| patSel | input | 2 | Reference select |
| chkInvert | input | 1 | Compare against the complemented reference |
| userPattern | input | PAT_W | Repeating user pattern |
| timeBase | input | 2 | Measurement window select |
| syncLost | output | 1 | High while the checker is not locked |
| errCount | output | CNT_W | Raw error count |
| errFloat | output | 8 | Compressed error count, exponent in the upper nibble |

## Verification
The assertions assume three things about the inputs:
- Reset is applied before use.
- The window exponents rise in the order short, medium, long, and each is at least log2 of DATA_W.
- The history invariant holds: while locked, the stored error history never exceeds the loss limit, so a loss always needs fresh errors in the current word.

The stimulus changes `patSel`, `chkInvert` and `timeBase` only in cycles with `dataValid` low. Where lock must survive, the stimulus keeps injected errors at no more than 8 per 64 bits. Lock is forced to drop by sending whole inverted words. A second instance with a narrow counter is used so that saturation in infinite mode can be reached in a short run.

// File: rtl/pattern_err_pkg.sv
package pattern_err_pkg;

  // Feedback taps: s[n] = s[n-A] ^ s[n-B]
  localparam int SHORT_TAP_A = 6;
  localparam int SHORT_TAP_B = 7;
  localparam int LONG_TAP_A  = 28;
  localparam int LONG_TAP_B  = 31;
  localparam int HIST_W      = LONG_TAP_B;

  typedef enum logic [1:0] {
    TB_INFINITE = 2'd0,
    TB_SHORT    = 2'd1,
    TB_MID      = 2'd2,
    TB_LONG     = 2'd3
  } timeBase_e;

  typedef enum logic [1:0] {
    REF_SHORT = 2'd0,
    REF_LONG  = 2'd1,
    REF_USER  = 2'd2,
    REF_USER2 = 2'd3
  } refSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic inSync;
    logic acquire;
    logic lose;
    logic winEnd;
    logic tbChange;
    logic infinite;
    logic countEn;
  } ctrlStrobe_t;

endpackage

// File: rtl/pec_float.sv
module pec_float #(
  parameter int CNT_W = 40
) (
  input  logic [CNT_W-1:0] countIn,
  output logic [7:0]       floatOut
);
  localparam int MANT_W  = 4;
  localparam int EXP_MAX = 15;

  int msbPos;
  int expo;
  logic [CNT_W-1:0] shifted;

  always_comb begin
    msbPos = 0;
    for (int i = 0; i < CNT_W; i++) begin
      if (countIn[i]) msbPos = i;
    end
    expo    = (msbPos < MANT_W) ? 0 : msbPos - (MANT_W - 1);
    shifted = countIn >> expo;
    if (expo > EXP_MAX) floatOut = 8'hFF;
    else                floatOut = {expo[3:0], shifted[MANT_W-1:0]};
  end

endmodule

// File: rtl/pec_ctrl.sv
module pec_ctrl import pattern_err_pkg::*; #(
  parameter int DATA_W    = 8,
  parameter int SYNC_BITS = 64,
  parameter int LOS_WIN   = 64,
  parameter int LOS_LIMIT = 8,
  parameter int WIN_EXP_S = 20,
  parameter int WIN_EXP_M = 26,
  parameter int WIN_EXP_L = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            dataValid,
  input  logic [1:0]                      timeBase,
  input  logic [DATA_W-1:0]               errVec,
  input  logic [$clog2(DATA_W+1)-1:0]     wordErrs,
  output ctrlStrobe_t                     strb,
  output logic                            syncLost
);
  localparam int ERR_W = $clog2(DATA_W + 1);
  localparam int GR_W  = $clog2(SYNC_BITS + DATA_W + 1);
  localparam int HE_W  = $clog2(LOS_WIN + 1);
  localparam int WC_W  = WIN_EXP_L + 1;

  logic              inSync;
  logic [GR_W-1:0]   goodRun, runNext;
  logic [LOS_WIN-1:0] errHist, histNext;
  logic [HE_W-1:0]   histErrs;
  logic [1:0]        tbPrev;
  logic [WC_W-1:0]   bitCnt, bitNext, winLen;
  logic              acquire, lose, winEnd, tbChange, infinite;

  // Error history of the last LOS_WIN checked bits
  always_comb begin
    histNext = {errHist[LOS_WIN-DATA_W-1:0], errVec};
    histErrs = '0;
    for (int i = 0; i < LOS_WIN; i++) histErrs = histErrs + HE_W'(histNext[i]);
  end

  always_comb begin
    unique case (timeBase_e'(timeBase))
      TB_SHORT: winLen = WC_W'(1) << WIN_EXP_S;
      TB_MID:   winLen = WC_W'(1) << WIN_EXP_M;
      TB_LONG:  winLen = WC_W'(1) << WIN_EXP_L;
      default:  winLen = '0;
    endcase
  end

  assign infinite = (timeBase_e'(timeBase) == TB_INFINITE);
  assign tbChange = (timeBase != tbPrev);
  assign runNext  = goodRun + GR_W'(DATA_W);
  assign bitNext  = bitCnt + WC_W'(DATA_W);
  assign acquire  = !inSync && dataValid && (wordErrs == '0) && (runNext >= GR_W'(SYNC_BITS));
  assign lose     = inSync && dataValid && (histErrs > HE_W'(LOS_LIMIT));
  assign winEnd   = inSync && dataValid && !infinite && !tbChange && (bitNext >= winLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSync  <= 1'b0;
      goodRun <= '0;
      errHist <= '0;
      tbPrev  <= 2'd0;
      bitCnt  <= '0;
    end else begin
      tbPrev <= timeBase;
      if (acquire) begin
        inSync  <= 1'b1;
        goodRun <= '0;
        errHist <= '0;
      end else if (lose) begin
        inSync  <= 1'b0;
        goodRun <= '0;
      end else begin
        if (!inSync && dataValid) goodRun <= (wordErrs == '0) ? runNext : '0;
        if (inSync && dataValid)  errHist <= histNext;
      end
      if (tbChange || acquire || lose || winEnd) bitCnt <= '0;
      else if (inSync && dataValid && !infinite) bitCnt <= bitNext;
    end
  end

  always_comb begin
    strb.inSync   = inSync;
    strb.acquire  = acquire;
    strb.lose     = lose;
    strb.winEnd   = winEnd;
    strb.tbChange = tbChange;
    strb.infinite = infinite;
    strb.countEn  = inSync && dataValid;
  end
  assign syncLost = !inSync;

  // R6: a loss always needs fresh errors in the current word
  p_loss_needs_errors_r6: assert property (@(posedge clk) disable iff (!rstN)
    lose |-> (wordErrs != '0));

  // R12: an invalid cycle never changes the lock state
  p_idle_keeps_lock_r12: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |=> $stable(syncLost));

endmodule

// File: rtl/pec_datapath.sv
module pec_datapath import pattern_err_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 40,
  parameter int PAT_W  = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [DATA_W-1:0]           dataIn,
  input  logic                        dataValid,
  input  logic [1:0]                  patSel,
  input  logic                        chkInvert,
  input  logic [PAT_W-1:0]            userPattern,
  input  ctrlStrobe_t                 strb,
  output logic [DATA_W-1:0]           errVec,
  output logic [$clog2(DATA_W+1)-1:0] wordErrs,
  output logic [CNT_W-1:0]            errCount
);
  localparam int ERR_W = $clog2(DATA_W + 1);
  localparam int PTR_W = $clog2(PAT_W);
  localparam int SUM_W = CNT_W + 1;

  logic [HIST_W-1:0] hist, workHist;
  logic [PTR_W-1:0]  ptr, idx;
  logic              rxBit, predBit, slip;
  logic [CNT_W-1:0]  liveCnt, heldCnt, satLive;
  logic [SUM_W-1:0]  sum;

  // Bit-serial prediction across the word, bit 0 first
  always_comb begin
    workHist = hist;
    errVec   = '0;
    idx      = ptr;
    rxBit    = 1'b0;
    predBit  = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      idx   = ptr + PTR_W'(i);
      rxBit = dataIn[i] ^ chkInvert;
      unique case (refSel_e'(patSel))
        REF_SHORT: predBit = workHist[SHORT_TAP_A-1] ^ workHist[SHORT_TAP_B-1];
        REF_LONG:  predBit = workHist[LONG_TAP_A-1] ^ workHist[LONG_TAP_B-1];
        default:   predBit = userPattern[idx];
      endcase
      errVec[i] = rxBit ^ predBit;
      // Out of lock: self-seed from received bits; in lock: free-run
      workHist  = {workHist[HIST_W-2:0], strb.inSync ? predBit : rxBit};
    end
  end

  always_comb begin
    wordErrs = '0;
    for (int i = 0; i < DATA_W; i++) wordErrs = wordErrs + ERR_W'(errVec[i]);
  end

  assign slip    = !strb.inSync && patSel[1] && (wordErrs != '0);
  assign sum     = {1'b0, liveCnt} + SUM_W'(wordErrs);
  assign satLive = sum[CNT_W] ? '1 : sum[CNT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist <= '0;
      ptr  <= '0;
    end else if (dataValid) begin
      hist <= workHist;
      ptr  <= ptr + PTR_W'(DATA_W) + PTR_W'(slip);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveCnt <= '0;
      heldCnt <= '0;
    end else if (strb.tbChange) begin
      liveCnt <= '0;
      heldCnt <= '0;
    end else if (strb.lose) begin
      liveCnt <= '1;
      heldCnt <= '1;
    end else if (strb.acquire) begin
      liveCnt <= '0;
      heldCnt <= '0;
    end else if (strb.countEn) begin
      if (strb.winEnd) begin
        heldCnt <= satLive;
        liveCnt <= '0;
      end else begin
        liveCnt <= satLive;
        if (strb.infinite) heldCnt <= satLive;
      end
    end
  end

  assign errCount = heldCnt;

  p_sync_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.acquire |=> (heldCnt == '0));

  p_lose_ones_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lose && !strb.tbChange) |=> (&heldCnt));

  p_tb_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.tbChange |=> (heldCnt == '0));

  p_window_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.infinite && !strb.winEnd && !strb.lose && !strb.acquire && !strb.tbChange)
      |=> $stable(heldCnt));

  p_saturate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.infinite && strb.countEn && (&liveCnt) && !strb.lose && !strb.tbChange)
      |=> (&heldCnt));

endmodule

// File: rtl/pattern_err_checker.sv
module pattern_err_checker import pattern_err_pkg::*; #(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 40,
  parameter int PAT_W     = 64,
  parameter int SYNC_BITS = 64,
  parameter int LOS_WIN   = 64,
  parameter int LOS_LIMIT = 8,
  parameter int WIN_EXP_S = 20,
  parameter int WIN_EXP_M = 26,
  parameter int WIN_EXP_L = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataValid,
  input  logic [1:0]        patSel,
  input  logic              chkInvert,
  input  logic [PAT_W-1:0]  userPattern,
  input  logic [1:0]        timeBase,
  output logic              syncLost,
  output logic [CNT_W-1:0]  errCount,
  output logic [7:0]        errFloat
);
  localparam int ERR_W = $clog2(DATA_W + 1);

  ctrlStrobe_t       strb;
  logic [DATA_W-1:0] errVec;
  logic [ERR_W-1:0]  wordErrs;

  pec_ctrl #(
    .DATA_W(DATA_W), .SYNC_BITS(SYNC_BITS), .LOS_WIN(LOS_WIN), .LOS_LIMIT(LOS_LIMIT),
    .WIN_EXP_S(WIN_EXP_S), .WIN_EXP_M(WIN_EXP_M), .WIN_EXP_L(WIN_EXP_L)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .dataValid(dataValid), .timeBase(timeBase),
    .errVec(errVec), .wordErrs(wordErrs), .strb(strb), .syncLost(syncLost)
  );

  pec_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PAT_W(PAT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .dataValid(dataValid), .patSel(patSel),
    .chkInvert(chkInvert), .userPattern(userPattern), .strb(strb),
    .errVec(errVec), .wordErrs(wordErrs), .errCount(errCount)
  );

  pec_float #(.CNT_W(CNT_W)) i_float (.countIn(errCount), .floatOut(errFloat));

  // R10: a nonzero exponent always comes with a normalised mantissa
  p_float_norm_r10: assert property (@(posedge clk) disable iff (!rstN)
    (errFloat[7:4] != 4'd0) |-> errFloat[3]);

endmodule

// File: tb/test_pattern_err_checker.sv
module test_pattern_err_checker;
  localparam int W       = 8;
  localparam int CNT_W   = 40;
  localparam int SMALL_W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rstN;
  logic [W-1:0]     dataIn;
  logic             dataValid;
  logic [1:0]       patSel;
  logic             chkInvert;
  logic [63:0]      userPattern;
  logic [1:0]       timeBase;
  logic             syncLost, syncLostS;
  logic [CNT_W-1:0] errCount;
  logic [SMALL_W-1:0] errCountS;
  logic [7:0]       errFloat, errFloatS;

  pattern_err_checker #(.DATA_W(W), .CNT_W(CNT_W), .WIN_EXP_S(7), .WIN_EXP_M(9), .WIN_EXP_L(11))
  i_pattern_err_checker (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .dataValid(dataValid), .patSel(patSel),
    .chkInvert(chkInvert), .userPattern(userPattern), .timeBase(timeBase),
    .syncLost(syncLost), .errCount(errCount), .errFloat(errFloat));

  pattern_err_checker #(.DATA_W(W), .CNT_W(SMALL_W), .WIN_EXP_S(7), .WIN_EXP_M(9), .WIN_EXP_L(11))
  i_pattern_err_checker_sat (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .dataValid(dataValid), .patSel(patSel),
    .chkInvert(chkInvert), .userPattern(userPattern), .timeBase(timeBase),
    .syncLost(syncLostS), .errCount(errCountS), .errFloat(errFloatS));

  typedef struct {
    string              tag;
    logic               los;
    logic [CNT_W-1:0]   cnt;
    bit                 chkSmall;
    logic [SMALL_W-1:0] smallCnt;
  } expItem_t;

  expItem_t sbQueue[$];
  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  logic [6:0]  g7  = 7'h5A;
  logic [30:0] g31 = 31'h1234_5678;
  int          userPhase = 13;
  bit          zeroMode = 0;
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  function automatic logic [7:0] refFloat(logic [CNT_W-1:0] v);
    int e = 0;
    logic [CNT_W-1:0] s;
    while (e <= 15 && (v >> e) > 15) e++;
    if (e > 15) return 8'hFF;
    s = v >> e;
    return {4'(e), s[3:0]};
  endfunction

  task automatic checkVal(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expectations and compares against outputs
  always @(negedge clk) begin
    expItem_t it;
    if (sbQueue.size() > 0) begin
      it = sbQueue.pop_front();
      checkVal({it.tag, " syncLost"}, 64'(syncLost), 64'(it.los));
      checkVal({it.tag, " errCount"}, 64'(errCount), 64'(it.cnt));
      checkVal({it.tag, " errFloat R10"}, 64'(errFloat), 64'(refFloat(it.cnt)));
      if (it.chkSmall) checkVal({it.tag, " narrow errCount"}, 64'(errCountS), 64'(it.smallCnt));
    end
  end

  task automatic genWord(output logic [W-1:0] w);
    logic b;
    for (int i = 0; i < W; i++) begin
      if (zeroMode) b = 1'b0;
      else if (patSel == 2'd0) begin b = g7[5] ^ g7[6];   g7  = {g7[5:0], b};  end
      else if (patSel == 2'd1) begin b = g31[27] ^ g31[30]; g31 = {g31[29:0], b}; end
      else begin b = userPattern[userPhase % 64]; userPhase++; end
      w[i] = b;
    end
  endtask

  task automatic sendWord(input logic [W-1:0] mask);
    logic [W-1:0] w;
    genWord(w);
    @(negedge clk);
    dataIn    = w ^ {W{chkInvert}} ^ mask;
    dataValid = 1'b1;
  endtask

  task automatic sendClean(input int n);
    for (int i = 0; i < n; i++) sendWord('0);
  endtask

  task automatic idle();
    @(negedge clk);
    dataValid = 1'b0;
  endtask

  task automatic expectState(string tag, logic los, logic [CNT_W-1:0] cnt);
    expItem_t it;
    idle();
    it.tag = tag; it.los = los; it.cnt = cnt; it.chkSmall = 0; it.smallCnt = '0;
    sbQueue.push_back(it);
  endtask

  task automatic expectBoth(string tag, logic los, logic [CNT_W-1:0] cnt, logic [SMALL_W-1:0] sc);
    expItem_t it;
    idle();
    it.tag = tag; it.los = los; it.cnt = cnt; it.chkSmall = 1; it.smallCnt = sc;
    sbQueue.push_back(it);
  endtask

  task automatic setMode(logic [1:0] sel, logic inv, bit zero);
    idle();
    patSel = sel; chkInvert = inv; zeroMode = zero;
  endtask

  task automatic setTb(logic [1:0] t);
    idle();
    timeBase = t;
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; dataIn = '0; dataValid = 1'b0; patSel = 2'd0; chkInvert = 1'b0;
    userPattern = 64'hC4E1_9A3D_7B05_26F8; timeBase = 2'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expectState("R1 reset", 1'b1, '0);

    // Short sequence, infinite window
    sendClean(20);
    expectState("R3 lock short", 1'b0, '0);
    sendWord(8'h01); sendWord(8'h00); sendWord(8'h10); sendWord(8'h80);
    expectState("R5 single errors", 1'b0, 40'd3);
    sendWord(8'h24);
    expectState("R5 two-bit word", 1'b0, 40'd5);
    sendClean(8);
    for (int i = 0; i < 15; i++) sendWord(8'h02);
    expectState("R10 count 20", 1'b0, 40'd20);

    // Forced loss of lock
    sendClean(8);
    sendWord(8'hFF); sendWord(8'hFF);
    expectState("R6 loss forces ones", 1'b1, ALL_ONES);
    sendClean(3);
    expectState("R6 stays at ones", 1'b1, ALL_ONES);
    sendClean(20);
    expectState("R4 relock clears", 1'b0, '0);

    // Time base change and finite windows
    sendWord(8'h01); sendWord(8'h01);
    expectState("R5 before tb change", 1'b0, 40'd2);
    setTb(2'd1);
    expectState("R9 tb change clears", 1'b0, '0);
    sendWord(8'h07); sendClean(14);
    expectState("R8 mid window held", 1'b0, '0);
    sendClean(1);
    expectState("R8 window end latch", 1'b0, 40'd3);
    sendWord(8'h01); sendClean(7);
    expectState("R8 second window held", 1'b0, 40'd3);
    sendClean(8);
    expectState("R8 second window latch", 1'b0, 40'd1);
    setTb(2'd2);
    expectState("R9 second tb change", 1'b0, '0);
    sendWord(8'h01); sendClean(62);
    expectState("R7 mid window tb2", 1'b0, '0);
    sendClean(1);
    expectState("R7 window tb2 end", 1'b0, 40'd1);
    setTb(2'd0);

    // Long sequence, inverted
    setMode(2'd1, 1'b1, 0);
    sendClean(40);
    expectState("R2 lock long inverted", 1'b0, '0);
    sendWord(8'h40);
    expectState("R2 long error", 1'b0, 40'd1);

    // User pattern with phase slip
    setMode(2'd2, 1'b0, 0);
    sendClean(120);
    expectState("R3 lock user pattern", 1'b0, '0);
    sendWord(8'h08);
    expectState("R2 user error", 1'b0, 40'd1);

    // All zeros stream
    setMode(2'd0, 1'b0, 1);
    sendClean(30);
    expectState("R11 all zeros", 1'b0, '0);

    // Invalid cycles with garbage data
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      dataIn = 8'hFF; dataValid = 1'b0;
    end
    expectState("R12 invalid ignored", 1'b0, '0);
    sendClean(3);
    expectState("R12 after invalid", 1'b0, '0);

    // Saturation in infinite mode on the narrow instance
    for (int i = 0; i < 300; i++) sendWord(8'h01);
    expectBoth("R7 saturation", 1'b0, 40'd300, 8'hFF);

    while (sbQueue.size() > 0) @(negedge clk);
    idle();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule